// File: doc/BRIEF.md
# Cascadable Codec Serial Port

This block is the codec side of a synchronous, full-duplex serial link to a host signal processor. A single 16-bit shift register carries traffic in both directions. The codec always starts a transfer. When an output sample event arrives, the newest ADC word is loaded into the shift register. The port drives a one-bit-period frame sync and then shifts the word out on `sdo`, most significant bit first. At the same moment it shifts the host's word in from `sdi`, also most significant bit first. Because the codec starts every transfer, the outgoing sample and the incoming word share the register without colliding.

The port keeps eight 8-bit configuration registers. Register 0 holds the decode mode in bits 1:0. Register 1 holds the serial bit rate in bits 3:2. A received word is handled in one of three ways, depending on the mode:
- as a configuration access, which is a register write or a read request;
- as a 16-bit DAC word;
- as either of the two, chosen by the word's MSB, with DAC data then limited to 15 bits.

A read request makes the port send the addressed register, in place of an ADC sample, in the next frame.

Top module: `codec_serport`

## Requirements
- R1: After reset, `fs`, `sdo` and `dac_vld` are 0. All configuration registers are 0, so the port is in configuration mode with a bit period of one clock.
- R2: A `sample_evt` accepted while idle sets `fs` for exactly one bit period, starting the next cycle. After that, `sdo` presents the 16 outgoing bits MSB first, each bit held for one bit period.
- R3: `sdi` is sampled at the end of each bit period, and the first bit sampled becomes bit 15 of the received word.
- R4: The bit period is 2^k clock cycles, where k is bits 3:2 of register 1. A new value takes effect from the next frame.
- R5: When bit 0 of register 0 is 0, every received word is a configuration access. Bits 10:8 give the address and bit 11 is the read flag. With bit 11 = 0, bits 7:0 are written into the addressed register. A configuration access never raises `dac_vld`.
- R6: A read request (bit 11 = 1) replaces the next frame's outgoing word with {1, 0000, address, register value}. The frame after that carries the ADC word again.
- R7: With register 0 bits 1:0 = 01 (data mode), each received word appears on `dac_data` with `dac_vld` high for one cycle, in the cycle after the frame's last bit. No register changes.
- R8: With register 0 bits 1:0 = 11 (mixed mode), a word with MSB = 1 is a configuration access, decoded as in R5. A word with MSB = 0 gives `dac_data` = {word[14:0], 0}.
- R9: The outgoing word is the `adc_word` value present in the cycle that `sample_evt` is accepted. Later changes to `adc_word` do not alter the frame.
- R10: A `sample_evt` during a frame is ignored, and the frame continues unchanged. Activity on `sdi` outside a frame has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_evt | input | 1 | Output sample event pulse |
| adc_word | input | 16 | Latest ADC sample |
| sdi | input | 1 | Serial data from host |
| sdo | output | 1 | Serial data to host |
| fs | output | 1 | Frame sync, one bit period before the first bit |
| dac_vld | output | 1 | DAC word strobe |
| dac_data | output | 16 | DAC word |

## Verification
The hardest situation to reach is the frame that directly follows a read request. In that frame the queued read-back word must win over the ADC sample, even when the next sample event lands in the very cycle in which the request is decoded. The bench starts each new frame on the first cycle after the previous frame's last bit, so this same-cycle case occurs on every back-to-back read. Random control words also move the port between modes and bit rates while frames keep running. Data mode can only be left through reset, so the bench applies reset after a few data-mode frames.

// File: rtl/csp_pkg.sv
package csp_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_SYNC, ST_SHIFT} csp_st_t;

  localparam int MODE_REG    = 0;
  localparam int RATE_REG    = 1;
  localparam int RATE_LSB    = 2;
  localparam int CW_RD_BIT   = 11;
  localparam int CW_ADDR_LSB = 8;

  // A word is a configuration access in config mode, or in mixed mode with MSB set
  function automatic logic word_is_cfg(input logic [1:0] mode, input logic msb);
    if (!mode[0]) return 1'b1;
    if (!mode[1]) return 1'b0;
    return msb;
  endfunction
endpackage

// File: rtl/csp_tick.sv
module csp_tick #(
  parameter int RATE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [RATE_W-1:0] rate,
  output logic              tick
);
  localparam int DIV_W = (1 << RATE_W) - 1;

  logic [DIV_W-1:0] cnt_q, cnt_nxt;
  logic [DIV_W:0]   lim_w;

  always_comb begin
    lim_w = ({{DIV_W{1'b0}}, 1'b1} << rate) - 1'b1;
    tick  = run && (cnt_q == lim_w[DIV_W-1:0]);
    if (!run || tick) cnt_nxt = '0;
    else              cnt_nxt = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nxt;
  end

  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && rate != '0) |=> !tick); // R4
endmodule

// File: rtl/csp_engine.sv
module csp_engine
  import csp_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         sample_evt,
  input  logic [W-1:0] load_word,
  input  logic         sdi,
  output logic         sdo,
  output logic         fs,
  output logic         run,
  output logic         load_ack,
  output logic         rx_done,
  output logic [W-1:0] rx_word
);
  localparam int BCNT_W = $clog2(W);

  csp_st_t           st_q, st_nxt;
  logic [W-1:0]      sr_q, sr_nxt, rxw_nxt;
  logic [BCNT_W-1:0] bcnt_q, bcnt_nxt;
  logic              done_nxt;

  always_comb begin
    st_nxt   = st_q;
    sr_nxt   = sr_q;
    bcnt_nxt = bcnt_q;
    done_nxt = 1'b0;
    rxw_nxt  = rx_word;
    load_ack = (st_q == ST_IDLE) && sample_evt;
    unique case (st_q)
      ST_IDLE: if (sample_evt) begin
        st_nxt   = ST_SYNC;
        sr_nxt   = load_word;
        bcnt_nxt = '0;
      end
      ST_SYNC: if (tick) st_nxt = ST_SHIFT;
      ST_SHIFT: if (tick) begin
        sr_nxt = {sr_q[W-2:0], sdi};
        if (bcnt_q == BCNT_W'(W-1)) begin
          st_nxt   = ST_IDLE;
          done_nxt = 1'b1;
          rxw_nxt  = {sr_q[W-2:0], sdi};
        end else begin
          bcnt_nxt = bcnt_q + 1'b1;
        end
      end
      default: st_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      sr_q    <= '0;
      bcnt_q  <= '0;
      rx_done <= 1'b0;
      rx_word <= '0;
    end else begin
      st_q    <= st_nxt;
      sr_q    <= sr_nxt;
      bcnt_q  <= bcnt_nxt;
      rx_done <= done_nxt;
      rx_word <= rxw_nxt;
    end
  end

  assign sdo = (st_q == ST_SHIFT) && sr_q[W-1];
  assign fs  = (st_q == ST_SYNC);
  assign run = (st_q != ST_IDLE);

  AST_FS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (fs && !tick) |=> fs); // R2
  AST_BIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SHIFT && !tick) |=> $stable(sdo)); // R2
  AST_START_ON_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> $past(sample_evt)); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> !rx_done); // R7
endmodule

// File: rtl/csp_regs.sv
module csp_regs
  import csp_pkg::*;
#(
  parameter int W      = 16,
  parameter int NREG   = 8,
  parameter int REG_W  = 8,
  parameter int RATE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_done,
  input  logic [W-1:0]      rx_word,
  input  logic              load_ack,
  input  logic [W-1:0]      adc_word,
  output logic [RATE_W-1:0] rate,
  output logic [W-1:0]      load_word,
  output logic              dac_vld,
  output logic [W-1:0]      dac_data
);
  localparam int ADDR_W = $clog2(NREG);
  localparam int PAD_W  = W - 1 - ADDR_W - REG_W;

  logic [REG_W-1:0]  regs_q [NREG];
  logic [1:0]        mode;
  logic              is_cfg, wr_stb, rd_stb, pend_q, pend_nxt;
  logic [ADDR_W-1:0] addr;
  logic [W-1:0]      rb_q, rb_nxt, rb_now;

  always_comb begin
    mode     = regs_q[MODE_REG][1:0];
    rate     = regs_q[RATE_REG][RATE_LSB +: RATE_W];
    is_cfg   = word_is_cfg(mode, rx_word[W-1]);
    addr     = rx_word[CW_ADDR_LSB +: ADDR_W];
    wr_stb   = rx_done && is_cfg && !rx_word[CW_RD_BIT];
    rd_stb   = rx_done && is_cfg &&  rx_word[CW_RD_BIT];
    rb_now   = {1'b1, {PAD_W{1'b0}}, addr, regs_q[addr]};
    dac_vld  = rx_done && !is_cfg;
    dac_data = mode[1] ? {rx_word[W-2:0], 1'b0} : rx_word;
    if (rd_stb)      load_word = rb_now;
    else if (pend_q) load_word = rb_q;
    else             load_word = adc_word;
    rb_nxt   = rd_stb ? rb_now : rb_q;
    if (rd_stb)        pend_nxt = !load_ack;
    else if (load_ack) pend_nxt = 1'b0;
    else               pend_nxt = pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      rb_q   <= '0;
    end else begin
      pend_q <= pend_nxt;
      rb_q   <= rb_nxt;
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic we;
    assign we = wr_stb && (addr == ADDR_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  regs_q[g] <= '0;
      else if (we) regs_q[g] <= rx_word[REG_W-1:0];
    end
  end

  AST_DATA_MODE_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mode == 2'b01) |-> (mode == 2'b01)); // R7
endmodule

// File: rtl/codec_serport.sv
module codec_serport #(
  parameter int W      = 16,
  parameter int NREG   = 8,
  parameter int REG_W  = 8,
  parameter int RATE_W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sample_evt,
  input  logic [W-1:0] adc_word,
  input  logic         sdi,
  output logic         sdo,
  output logic         fs,
  output logic         dac_vld,
  output logic [W-1:0] dac_data
);
  logic [1:0]        rst_sync_q;
  logic              rst_q, tick, run, load_ack, rx_done;
  logic [RATE_W-1:0] rate;
  logic [W-1:0]      load_word, rx_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q = rst_sync_q[1];

  csp_tick #(.RATE_W(RATE_W)) i_tick (
    .clk(clk), .rst_n(rst_q), .run(run), .rate(rate), .tick(tick)
  );

  csp_engine #(.W(W)) i_engine (
    .clk(clk), .rst_n(rst_q), .tick(tick), .sample_evt(sample_evt),
    .load_word(load_word), .sdi(sdi), .sdo(sdo), .fs(fs), .run(run),
    .load_ack(load_ack), .rx_done(rx_done), .rx_word(rx_word)
  );

  csp_regs #(.W(W), .NREG(NREG), .REG_W(REG_W), .RATE_W(RATE_W)) i_regs (
    .clk(clk), .rst_n(rst_q), .rx_done(rx_done), .rx_word(rx_word),
    .load_ack(load_ack), .adc_word(adc_word), .rate(rate),
    .load_word(load_word), .dac_vld(dac_vld), .dac_data(dac_data)
  );

  AST_DAC_AFTER_FRAME: assert property (@(posedge clk) disable iff (!rst_q)
    dac_vld |-> $past(run)); // R7
endmodule

// File: tb/test_codec_serport.sv
module test_codec_serport;
  logic        clk = 1'b0;
  logic        rst_n, sample_evt, sdi, sdo, fs, dac_vld;
  logic [15:0] adc_word, dac_data;
  int          n_chk = 0;
  int          n_err = 0;
  logic [7:0]  m_reg [8];
  logic        m_pend;
  logic [15:0] m_rb;

  always #10 clk = ~clk;

  codec_serport i_codec_serport (
    .clk(clk), .rst_n(rst_n), .sample_evt(sample_evt), .adc_word(adc_word),
    .sdi(sdi), .sdo(sdo), .fs(fs), .dac_vld(dac_vld), .dac_data(dac_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] cw(input logic flag, input logic rd,
                                     input logic [2:0] a, input logic [7:0] d);
    return {flag, 3'b000, rd, a, d};
  endfunction

  function automatic logic exp_cfg(input logic [1:0] mode, input logic [15:0] w);
    if (!mode[0]) return 1'b1;
    if (!mode[1]) return 1'b0;
    return w[15];
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; sample_evt = 1'b0; sdi = 1'b0; adc_word = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 8; i++) m_reg[i] = '0;
    m_pend = 1'b0; m_rb = '0;
    chk("R1 fs", fs, 0); chk("R1 sdo", sdo, 0); chk("R1 dac_vld", dac_vld, 0);
  endtask

  // One frame: starts at a negedge, ends at the negedge after the last bit
  task automatic xfer(input logic [15:0] adc, input logic [15:0] tx, input bit poke);
    int          p;
    logic [1:0]  mode;
    logic [15:0] exp_out;
    logic        cfg;
    p       = 1 << m_reg[1][3:2];
    mode    = m_reg[0][1:0];
    exp_out = m_pend ? m_rb : adc;
    m_pend  = 1'b0;
    cfg     = exp_cfg(mode, tx);
    sample_evt = 1'b1; adc_word = adc;
    @(negedge clk);
    sample_evt = 1'b0; adc_word = ~adc;  // R9: later value must not be sent
    for (int k = 0; k <= 17 * p; k++) begin
      if (k > 0) @(negedge clk);
      sample_evt = 1'b0;
      if (k < p) begin
        sdi = 1'($urandom);
        if (k == 0 || k == p - 1) chk("R2 fs high", fs, 1);
      end else if (k < 17 * p) begin
        int i;
        i = k / p - 1;
        sdi = tx[15 - i];
        if (k == p) chk("R2 fs low", fs, 0);
        if (k % p == 0) chk("R2/R6/R9 sdo bit", sdo, exp_out[15 - i]);
        if (k % p == p - 1) chk("R4 bit held", sdo, exp_out[15 - i]);
        if (poke && k == 3 * p) begin
          sample_evt = 1'b1;  // R10: ignored mid-frame
          adc_word = 16'hFFFF;
        end
      end else begin
        chk("R7/R8 dac_vld", dac_vld, !cfg);
        if (!cfg) chk("R3/R7/R8 dac_data", dac_data,
                      mode[1] ? {tx[14:0], 1'b0} : tx);
        chk("R2 fs idle", fs, 0);
        chk("R2 sdo idle", sdo, 0);
      end
    end
    sdi = 1'($urandom);
    if (cfg) begin
      if (tx[11]) begin
        m_pend = 1'b1;
        m_rb   = {1'b1, 4'b0000, tx[10:8], m_reg[tx[10:8]]};
      end else begin
        m_reg[tx[10:8]] = tx[7:0];
      end
    end
  endtask

  task automatic idle_noise(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      sdi = 1'($urandom);
      chk("R10 no dac_vld when idle", dac_vld, 0);
      chk("R10 no fs when idle", fs, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    int dm_cnt;
    void'($urandom(32'h5EED1234));
    do_reset();
    // R1/R5/R6: reset contents read back as zero
    xfer(16'h1234, cw(0, 1, 3'd0, 8'h00), 0);
    xfer(16'hA5C3, cw(0, 0, 3'd5, 8'hA5), 0);     // R6 readback {1,0000,000,00}
    xfer(16'h0F0F, cw(0, 1, 3'd5, 8'h00), 0);     // R5 write then R6 read
    xfer(16'h7001, cw(0, 1, 3'd5, 8'h00), 0);     // R6 0x85A5 out
    xfer(16'h3C3C, cw(0, 0, 3'd1, 8'h08), 0);     // R6 next read queued; R4 rate=2
    idle_noise(5);
    xfer(16'h9999, cw(0, 0, 3'd0, 8'h02), 1);     // R4 P=4, R10 poke; R5 bit0=0 stays cfg
    xfer(16'h4242, cw(0, 1, 3'd1, 8'h00), 0);
    xfer(16'h1111, cw(0, 0, 3'd0, 8'h03), 0);     // R6 reads rate reg; enter mixed
    xfer(16'h2222, 16'h5AB7, 0);                  // R8 data, MSB 0
    xfer(16'h3333, cw(1, 0, 3'd1, 8'h04), 1);     // R8 cfg, rate=1
    xfer(16'h4444, cw(1, 0, 3'd0, 8'h01), 0);     // enter data mode
    xfer(16'h5555, cw(0, 0, 3'd0, 8'h00), 0);     // R7 cfg-looking word goes to DAC
    xfer(16'h6666, 16'hFFFF, 0);                  // R7
    // Random phase
    do_reset();
    dm_cnt = 0;
    for (int n = 0; n < 70; n++) begin
      logic [15:0] tx;
      tx = 16'($urandom);
      if (tx[10:8] == 3'd0 && tx[1:0] == 2'b01 && ($urandom % 4) != 0) tx[0] = 1'b0;
      xfer(16'($urandom), tx, ($urandom % 5) == 0);
      if (m_reg[0][1:0] == 2'b01) dm_cnt++;
      if (dm_cnt >= 3) begin
        do_reset();
        dm_cnt = 0;
      end
      if (($urandom % 3) == 0) idle_noise(1 + $urandom % 3);
    end
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule